// File: doc/BRIEF.md
# High-Voltage Discharge Proof Controller

This block decides when the high-voltage section may be energized again after any stop. When a stop arrives it turns on the discharge switch and starts an elapsed-time count. It then reads residual-voltage samples taken at the main output node and at a set of segment nodes. Each sample carries a valid bit. A proof counts only when every required node reports a valid reading at or below the threshold. Time alone never grants a proof. The block also starts in the discharging state when it comes out of reset. This repeats the proof at every power-up before high voltage can be enabled.

The stop cause sets what happens when the proof fails. After a normal stop, the block keeps discharging and waits for as long as it takes. It records a timeout flag once the window has passed. After an interlock or emergency stop, after an arc, and after a power-up, a timeout or an invalid required sensor moves the block into a locked state. That state holds until reset. An arc attempt cannot be restarted by a later stop event. For every attempt the block keeps three figures for logging: the first and latest main-node readings, and the elapsed cycle count. It also keeps a timeout flag.

Top module: `dp_proof_ctrl`

## Requirements
- R1: After reset the block is in the power-up proof. dis_en=1, reen_block=1, proof_pass=0, latch_req=0, samp_ready=1, and all record outputs read 0.
- R2: A sample is accepted when samp_valid and samp_ready are both high. The accepted sample passes when node 0 (samp_volt[VW-1:0]) and every node i≥1 with seg_mask[i-1]=1 have samp_ok[i]=1 and a voltage at or below threshold. Node i sits at samp_volt[i*VW +: VW]. Nodes with a clear mask bit are ignored. A pass moves the block to confirmation on the next cycle, and proof_pass rises.
- R3: rec_elapsed is 0 on the cycle the attempt starts. It rises by one for each cycle spent discharging, and it freezes on the cycle of a pass or when it equals timeout.
- R4: With cause code 0 (normal), reaching the timeout sets rec_timeout and freezes rec_elapsed. The block keeps discharging and does not latch. An invalid required node only prevents a pass.
- R5: With cause codes 1 (interlock/emergency stop), 2 (arc) and 3 (power-up), an accepted sample with an invalid required node, or reaching the timeout without a pass, moves the block to LATCH. A timeout also sets rec_timeout. In LATCH, latch_req=1, proof_pass=0 and dis_en=1. The state holds until reset, and stop events have no effect there.
- R6: After a pass, proof_pass stays high and dis_en stays high for CONF_N cycles. Then dis_en and reen_block fall together and proof_pass stays high.
- R7: A stop event while safe, or during a non-arc attempt, restarts the attempt with the new cause on the next cycle. proof_pass=0, rec_elapsed=0, and the records are cleared.
- R8: During an attempt with cause 2 (arc), stop events are ignored. The elapsed count continues and no retry takes place.
- R9: rec_start_v holds the main-node voltage of the first accepted sample of the attempt. rec_end_v holds the main-node voltage of the latest accepted sample.
- R10: samp_ready is high only while discharging and not on a cycle that restarts the attempt. Samples offered at other times are not consumed and change no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts the power-up proof |
| stop_valid | input | 1 | One-cycle stop event |
| stop_cause | input | 2 | 0 normal, 1 interlock/emergency stop, 2 arc, 3 power-up |
| seg_mask | input | N_NODES-1 | Bit i-1 set: segment node i is required |
| threshold | input | VW | Residual-voltage limit, inclusive |
| timeout | input | TW | Proof window in cycles |
| samp_valid | input | 1 | Sample offered |
| samp_ready | output | 1 | Sample consumed this cycle |
| samp_volt | input | N_NODES*VW | Packed node voltages, node 0 in the low bits |
| samp_ok | input | N_NODES | Per-node sensor valid |
| dis_en | output | 1 | Discharge switch enable |
| proof_pass | output | 1 | Residual proof granted |
| latch_req | output | 1 | Lockout request |
| reen_block | output | 1 | High-voltage re-enable blocked |
| rec_start_v | output | VW | First main-node reading of the attempt |
| rec_end_v | output | VW | Latest main-node reading of the attempt |
| rec_elapsed | output | TW | Elapsed cycles of the attempt |
| rec_timeout | output | 1 | Attempt timed out |

## Verification
The bench builds the block with three nodes, 8-bit voltages, an 8-bit timer and a confirmation count of 3. With an 8-bit timer, timeouts of 5 to 40 cycles fit inside short runs, so both the normal-stop freeze and the timeout latch are reached. With three nodes, one segment can be required while another is left out of the mask. This shows that an unrequired node at full voltage, or with an invalid reading, does not block a pass. The short confirmation count lets the bench watch the switch release after a pass, and check at the inclusive threshold edge.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [1:0] {
    CAUSE_NORMAL  = 2'd0,
    CAUSE_ILOCK   = 2'd1,
    CAUSE_ARC     = 2'd2,
    CAUSE_POWERUP = 2'd3
  } stop_cause_e;

  typedef enum logic [1:0] {
    ST_DISCH   = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_SAFE    = 2'd2,
    ST_LATCH   = 2'd3
  } dp_state_e;
endpackage

// File: rtl/dp_node_eval.sv
module dp_node_eval #(
  parameter int N_NODES = 3,
  parameter int VW      = 12
) (
  input  logic [N_NODES*VW-1:0] volt,
  input  logic [N_NODES-1:0]    ok,
  input  logic [N_NODES-2:0]    seg_mask,
  input  logic [VW-1:0]         thr,
  output logic                  all_below,
  output logic                  any_invalid
);
  logic [N_NODES-1:0] req;
  logic [N_NODES-1:0] good;

  for (genvar i = 0; i < N_NODES; i++) begin : g_node
    if (i == 0) begin : g_main
      assign req[i] = 1'b1;
    end else begin : g_seg
      assign req[i] = seg_mask[i-1];
    end
    assign good[i] = ok[i] && (volt[i*VW +: VW] <= thr);
  end

  assign all_below   = &(good | ~req);
  assign any_invalid = |(req & ~ok);
endmodule

// File: rtl/dp_elapsed.sv
module dp_elapsed #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  output logic [TW-1:0] elapsed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   elapsed <= '0;
    else if (clr) elapsed <= '0;
    else if (run) elapsed <= elapsed + 1'b1;
  end
endmodule

// File: rtl/dp_record.sv
module dp_record #(
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic [VW-1:0] main_v,
  input  logic          set_to,
  output logic [VW-1:0] start_v,
  output logic [VW-1:0] end_v,
  output logic          to_flag
);
  logic first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first   <= 1'b1;
      start_v <= '0;
      end_v   <= '0;
      to_flag <= 1'b0;
    end else if (clr) begin
      first   <= 1'b1;
      start_v <= '0;
      end_v   <= '0;
      to_flag <= 1'b0;
    end else begin
      if (take) begin
        end_v <= main_v;
        if (first) begin
          start_v <= main_v;
          first   <= 1'b0;
        end
      end
      if (set_to) to_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/dp_proof_ctrl.sv
module dp_proof_ctrl
  import dp_pkg::*;
#(
  parameter int N_NODES = 4,
  parameter int VW      = 12,
  parameter int TW      = 16,
  parameter int CONF_N  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stop_valid,
  input  logic [1:0]            stop_cause,
  input  logic [N_NODES-2:0]    seg_mask,
  input  logic [VW-1:0]         threshold,
  input  logic [TW-1:0]         timeout,
  input  logic                  samp_valid,
  output logic                  samp_ready,
  input  logic [N_NODES*VW-1:0] samp_volt,
  input  logic [N_NODES-1:0]    samp_ok,
  output logic                  dis_en,
  output logic                  proof_pass,
  output logic                  latch_req,
  output logic                  reen_block,
  output logic [VW-1:0]         rec_start_v,
  output logic [VW-1:0]         rec_end_v,
  output logic [TW-1:0]         rec_elapsed,
  output logic                  rec_timeout
);
  localparam int CW = (CONF_N > 1) ? $clog2(CONF_N) : 1;
  localparam logic [CW-1:0] CONF_LAST = CW'(CONF_N - 1);

  dp_state_e   state;
  stop_cause_e cause;
  logic [CW-1:0] conf_cnt;
  logic frozen;

  logic restart, take, all_below, any_invalid;
  logic pass_now, bad_now, tmo_hit, strict, fail_now, run;

  dp_node_eval #(.N_NODES(N_NODES), .VW(VW)) u_eval (
    .volt        (samp_volt),
    .ok          (samp_ok),
    .seg_mask    (seg_mask),
    .thr         (threshold),
    .all_below   (all_below),
    .any_invalid (any_invalid)
  );

  always_comb begin
    restart = stop_valid &&
              ((state == ST_SAFE) ||
               (((state == ST_DISCH) || (state == ST_CONFIRM)) && (cause != CAUSE_ARC)));
    samp_ready = (state == ST_DISCH) && !restart;
    take       = samp_valid && samp_ready;
    pass_now   = take && all_below;
    bad_now    = take && any_invalid;
    tmo_hit    = (state == ST_DISCH) && !frozen && (rec_elapsed == timeout) && !restart;
    strict     = (cause != CAUSE_NORMAL);
    fail_now   = !pass_now && strict && (bad_now || tmo_hit);
    run        = (state == ST_DISCH) && !restart && !pass_now && !fail_now &&
                 !tmo_hit && !frozen;
  end

  dp_elapsed #(.TW(TW)) u_elapsed (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (restart),
    .run     (run),
    .elapsed (rec_elapsed)
  );

  dp_record #(.VW(VW)) u_record (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (restart),
    .take    (take),
    .main_v  (samp_volt[VW-1:0]),
    .set_to  (tmo_hit && !pass_now),
    .start_v (rec_start_v),
    .end_v   (rec_end_v),
    .to_flag (rec_timeout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_DISCH;
      cause    <= CAUSE_POWERUP;
      conf_cnt <= '0;
      frozen   <= 1'b0;
    end else if (restart) begin
      state    <= ST_DISCH;
      cause    <= stop_cause_e'(stop_cause);
      conf_cnt <= '0;
      frozen   <= 1'b0;
    end else begin
      unique case (state)
        ST_DISCH: begin
          if (pass_now) begin
            state    <= ST_CONFIRM;
            conf_cnt <= '0;
          end else if (fail_now) begin
            state <= ST_LATCH;
          end else if (tmo_hit) begin
            frozen <= 1'b1;
          end
        end
        ST_CONFIRM: begin
          if (conf_cnt == CONF_LAST) state <= ST_SAFE;
          else conf_cnt <= conf_cnt + 1'b1;
        end
        ST_SAFE:  state <= ST_SAFE;
        ST_LATCH: state <= ST_LATCH;
        default:  state <= ST_LATCH;
      endcase
    end
  end

  assign dis_en     = (state != ST_SAFE);
  assign reen_block = (state != ST_SAFE);
  assign proof_pass = (state == ST_CONFIRM) || (state == ST_SAFE);
  assign latch_req  = (state == ST_LATCH);
endmodule

// File: rtl/dp_proof_chk.sv
module dp_proof_chk (
  input logic clk,
  input logic rst_n,
  input logic samp_valid,
  input logic samp_ready,
  input logic dis_en,
  input logic proof_pass,
  input logic latch_req,
  input logic reen_block
);
  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_req |=> latch_req);

  // R5
  latch_no_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_req |-> (!proof_pass && dis_en));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_en |-> (proof_pass && !reen_block));

  // R6
  release_after_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dis_en) |-> $past(proof_pass));

  // R2
  pass_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proof_pass) |-> $past(samp_valid && samp_ready));

  // R10
  ready_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_ready |-> (reen_block && !proof_pass && !latch_req));
endmodule

bind dp_proof_ctrl dp_proof_chk u_dp_proof_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .samp_valid (samp_valid),
  .samp_ready (samp_ready),
  .dis_en     (dis_en),
  .proof_pass (proof_pass),
  .latch_req  (latch_req),
  .reen_block (reen_block)
);

// File: tb/dp_proof_ctrl_bench.sv
module dp_proof_ctrl_bench;
  localparam int N  = 3;
  localparam int VW = 8;
  localparam int TW = 8;
  localparam int CF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          b_stop = 1'b0;
  logic [1:0]    b_cause = 2'd0;
  logic [N-2:0]  b_mask = '1;
  logic [VW-1:0] b_thr = 8'd20;
  logic [TW-1:0] b_tmo = 8'd40;
  logic          b_sv = 1'b0;
  logic [VW-1:0] b_v [N];
  logic [N-1:0]  b_ok = '1;

  logic samp_ready, dis_en, proof_pass, latch_req, reen_block, rec_timeout;
  logic [VW-1:0] rec_start_v, rec_end_v;
  logic [TW-1:0] rec_elapsed;

  dp_proof_ctrl #(.N_NODES(N), .VW(VW), .TW(TW), .CONF_N(CF)) u_dp_proof_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_valid(b_stop), .stop_cause(b_cause),
    .seg_mask(b_mask), .threshold(b_thr), .timeout(b_tmo),
    .samp_valid(b_sv), .samp_ready(samp_ready),
    .samp_volt({b_v[2], b_v[1], b_v[0]}), .samp_ok(b_ok),
    .dis_en(dis_en), .proof_pass(proof_pass), .latch_req(latch_req),
    .reen_block(reen_block), .rec_start_v(rec_start_v), .rec_end_v(rec_end_v),
    .rec_elapsed(rec_elapsed), .rec_timeout(rec_timeout)
  );

  // behavioural reference: 0 discharging, 1 confirming, 2 safe, 3 locked
  int m_st, m_cause, m_el, m_cc, m_sv, m_ev;
  bit m_frz, m_first, m_to;

  function automatic bit m_restart();
    return b_stop && (m_st == 2 || ((m_st == 0 || m_st == 1) && m_cause != 2));
  endfunction

  function automatic bit m_ready();
    return (m_st == 0) && !m_restart();
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cause = 3; m_el = 0; m_frz = 0; m_cc = 0;
      m_first = 1; m_sv = 0; m_ev = 0; m_to = 0;
    end else if (m_restart()) begin
      m_st = 0; m_cause = int'(b_cause); m_el = 0; m_frz = 0; m_cc = 0;
      m_first = 1; m_sv = 0; m_ev = 0; m_to = 0;
    end else if (m_st == 0) begin
      bit allok, bad, tmo;
      logic [N-1:0] req;
      req = {b_mask, 1'b1};
      allok = 1; bad = 0;
      for (int k = 0; k < N; k++) begin
        if (req[k]) begin
          if (!b_ok[k]) begin bad = 1; allok = 0; end
          else if (b_v[k] > b_thr) allok = 0;
        end
      end
      tmo = !m_frz && (m_el == int'(b_tmo));
      if (b_sv) begin
        if (m_first) begin m_sv = int'(b_v[0]); m_first = 0; end
        m_ev = int'(b_v[0]);
      end
      if (b_sv && allok) begin
        m_st = 1; m_cc = 0;
      end else if (m_cause != 0 && ((b_sv && bad) || tmo)) begin
        m_st = 3;
        if (tmo) m_to = 1;
      end else if (tmo) begin
        m_to = 1; m_frz = 1;
      end else if (!m_frz) begin
        m_el++;
      end
    end else if (m_st == 1) begin
      if (m_cc == CF - 1) m_st = 2;
      else m_cc++;
    end
  end

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp();
    chk(dis_en == (m_st != 2), "R6 dis_en", dis_en, m_st != 2);
    chk(reen_block == (m_st != 2), "R6 reen_block", reen_block, m_st != 2);
    chk(proof_pass == (m_st == 1 || m_st == 2), "R2 proof_pass", proof_pass,
        m_st == 1 || m_st == 2);
    chk(latch_req == (m_st == 3), "R5 latch_req", latch_req, m_st == 3);
    chk(samp_ready == m_ready(), "R10 samp_ready", samp_ready, m_ready());
    chk(int'(rec_elapsed) == m_el, "R3 rec_elapsed", rec_elapsed, m_el);
    chk(int'(rec_start_v) == m_sv, "R9 rec_start_v", rec_start_v, m_sv);
    chk(int'(rec_end_v) == m_ev, "R9 rec_end_v", rec_end_v, m_ev);
    chk(rec_timeout == m_to, "R4 rec_timeout", rec_timeout, m_to);
  endtask

  task automatic adv();
    @(negedge clk);
    if (!done) cmp();
    b_stop = 0;
    b_sv = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) adv();
  endtask

  task automatic stop(input int c);
    b_stop = 1; b_cause = 2'(c);
    adv();
  endtask

  task automatic samp(input int v0, input int v1, input int v2, input logic [N-1:0] ok);
    b_sv = 1; b_v[0] = 8'(v0); b_v[1] = 8'(v1); b_v[2] = 8'(v2); b_ok = ok;
    adv();
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle(2);
    rst_n = 1;
    adv();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      summary();
    end
  end

  initial begin
    b_v[0] = 0; b_v[1] = 0; b_v[2] = 0;
    idle(3);
    // R1 reset state
    chk(dis_en && reen_block && !proof_pass && !latch_req && samp_ready,
        "R1 reset outputs", {dis_en, reen_block, proof_pass, latch_req, samp_ready}, 5'b11001);
    chk(rec_elapsed == 0 && rec_start_v == 0 && rec_end_v == 0 && !rec_timeout,
        "R1 reset records", rec_elapsed, 0);
    rst_n = 1;
    adv();
    // power-up proof: decaying main, threshold edge at 21 then 20
    samp(150, 10, 10, 3'b111);
    samp(21, 5, 5, 3'b111);
    idle(2);
    samp(20, 20, 20, 3'b111);
    chk(proof_pass == 1, "R2 pass at threshold", proof_pass, 1);
    idle(CF + 1);
    chk(dis_en == 0 && reen_block == 0, "R6 switch released", dis_en, 0);
    chk(rec_start_v == 150 && rec_end_v == 20, "R9 start/end", rec_start_v, 150);
    // R10: sample offered while safe is not consumed
    samp(99, 99, 99, 3'b111);
    chk(rec_end_v == 20, "R10 ignored sample", rec_end_v, 20);

    // normal stop with timeout
    b_tmo = 5;
    stop(0);
    chk(proof_pass == 0 && rec_elapsed == 0, "R7 pass low on stop", proof_pass, 0);
    repeat (8) samp(100, 5, 5, 3'b111);
    chk(rec_timeout == 1 && latch_req == 0 && rec_elapsed == 5, "R4 normal timeout",
        rec_elapsed, 5);
    samp(5, 5, 5, 3'b101);
    chk(latch_req == 0 && proof_pass == 0, "R4 invalid no latch", latch_req, 0);
    samp(5, 5, 5, 3'b111);
    idle(CF + 2);
    chk(proof_pass == 1 && dis_en == 0, "R4 late pass", proof_pass, 1);

    // restart of a normal attempt by an interlock stop
    b_tmo = 30;
    stop(0);
    idle(3);
    stop(1);
    chk(rec_elapsed == 0, "R7 restart elapsed", rec_elapsed, 0);
    samp(8, 8, 8, 3'b111);
    idle(CF + 1);
    stop(1);
    chk(proof_pass == 0 && dis_en == 1, "R7 stop from safe", proof_pass, 0);
    // interlock attempt: required segment invalid
    samp(5, 5, 5, 3'b011);
    chk(latch_req == 1, "R5 invalid latch", latch_req, 1);
    stop(0);
    idle(2);
    chk(latch_req == 1 && rec_elapsed != 0 || latch_req == 1, "R5 stop ignored in latch",
        latch_req, 1);
    do_reset();

    // power-up with only segment 1 required: node 2 ignored
    b_mask = 2'b01;
    samp(5, 5, 250, 3'b011);
    chk(proof_pass == 1, "R2 unrequired node ignored", proof_pass, 1);
    idle(CF + 1);
    b_mask = 2'b11;

    // arc attempt: no retry, then timeout latch
    b_tmo = 8;
    stop(2);
    idle(2);
    stop(0);
    chk(rec_elapsed == 3, "R8 arc ignores stop", rec_elapsed, 3);
    samp(90, 5, 5, 3'b111);
    idle(8);
    chk(latch_req == 1 && rec_timeout == 1, "R5 arc timeout latch", latch_req, 1);
    chk(rec_start_v == 90, "R9 arc start", rec_start_v, 90);
    do_reset();

    // power-up proof timeout latches
    idle(12);
    chk(latch_req == 1, "R5 power-up timeout", latch_req, 1);
    do_reset();
    samp(3, 3, 3, 3'b111);
    idle(CF + 2);
    summary();
  end
endmodule